// File: doc/BRIEF.md
# Destination Address Match Filter

This block decides, for each received frame, whether the frame is kept, judging only its 48-bit destination address. Three host-controlled enables open the filter for promiscuous unicast traffic, for all group-addressed traffic and for the all-ones address. A 16-entry address table, masked by a 16-bit enable word, accepts further specific addresses. The verdict carries an accept flag and a type code that a receive status path can merge directly into its status word.

The table is filled by a list walker. The host places a list of records in memory, sets a record count and a start pointer, and pulses a start input. The walker fetches every record over a simple request/acknowledge read port. Each record holds a slot number and three address words. After the records it fetches one more word, which becomes the enable mask, and then reports completion. While the host holds the block in its reset mode, it can read any stored address back one word at a time.

Top module: `dst_match_filter`

## Requirements
- R1: With promiscuous enabled and bit 0 of the destination clear (unicast), the frame is accepted with type code 0x0000. This rule outranks every other rule.
- R2: Otherwise, with all-group enabled and destination bit 0 set, the frame is accepted with type code 0x0100. This holds even when the address is all ones.
- R3: Otherwise, with broadcast enabled and all 48 destination bits set, the frame is accepted with type code 0x0080.
- R4: Otherwise, the frame is accepted with type code 0x0000 if some slot i has enable bit i set and its stored words equal the destination (word 0 = bits 15:0, byte 0 in bits 7:0; word 1 = bits 31:16; word 2 = bits 47:32). If no slot matches, the frame is rejected with type code 0x0000.
- R5: The verdict is presented for exactly one cycle, two clock edges after the edge that samples the destination strobe. The enables are sampled at that first edge. Strobes on back-to-back cycles give back-to-back verdicts.
- R6: A load fetches each record as four words in order. The first is a slot word, of which only bits 3:0 select the slot. The other three are address words 0, 1 and 2, stored into that slot. Word n of a record lies at the record base plus 2n bytes in 16-bit mode, or plus 4n bytes in 32-bit mode. Each request holds its address steady until it is acknowledged.
- R7: Only the low 5 bits of the count are used. After each record the count drops by one and the record base moves on by 8 bytes (16-bit mode) or 16 bytes (32-bit mode). The width mode is sampled when the load starts.
- R8: When the count reaches zero, one word is read at the current record base and becomes the enable mask. On the cycle after that acknowledge, the done output pulses high for one cycle and busy is low.
- R9: A load started with a count of zero performs only the enable-word read.
- R10: A start pulse while a load is busy is ignored. It causes no extra memory reads and leaves the count and pointer of the running load unchanged.
- R11: In reset mode, read port k (0, 1, 2) returns address word 2−k of the selected slot, and port value 3 returns zero. Outside reset mode the read data is zero. Read data is registered and appears one edge after the selection.
- R12: After reset the enable mask, all table slots, the verdict, busy, done, the memory request and the read data are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| promisc_en | input | 1 | Accept any unicast destination |
| allmc_en | input | 1 | Accept any group destination |
| bcast_en | input | 1 | Accept the all-ones destination |
| wide_mode | input | 1 | 1: memory words are 32 bits apart; 0: 16 bits |
| dst_valid | input | 1 | Destination strobe |
| dst_addr | input | 48 | Destination address, byte 0 in bits 7:0 |
| verdict_valid | output | 1 | Verdict strobe |
| verdict_accept | output | 1 | 1 = keep the frame |
| verdict_kind | output | 16 | Type code: 0x0100 group, 0x0080 broadcast, else 0 |
| load_start | input | 1 | Start a table load |
| load_count | input | 5 | Number of records |
| load_ptr | input | 16 | Byte address of the first record |
| load_busy | output | 1 | Load in progress |
| load_done | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 16 | Memory read byte address |
| mem_ack | input | 1 | Read data valid, ends the request |
| mem_rdata | input | 16 | Read data |
| cam_enable | output | 16 | Current slot enable mask |
| host_reset_mode | input | 1 | Block is in reset mode; readback allowed |
| host_entry | input | 4 | Slot to read back |
| host_port | input | 2 | Read port k |
| host_rdata | output | 16 | Readback data |

## Verification
The bench builds the block with its default parameters: 16 slots, 16-bit words, a 16-bit memory address and a 5-bit count. With these values, slot numbers up to 15 can be reached from slot words whose upper bits are set. Both record strides can be exercised, as can a mask that enables some loaded slots and leaves others disabled. The bench compares every cycle against a behavioural model. It runs loads of zero, two and four records with variable memory latency, a start pulse ignored mid-load, and reloads that overwrite a slot. It also covers every ordering conflict between the promiscuous, group, broadcast and table rules.

// File: rtl/dmf_pkg.sv
package dmf_pkg;
  localparam logic [15:0] KIND_NONE  = 16'h0000;
  localparam logic [15:0] KIND_GROUP = 16'h0100;
  localparam logic [15:0] KIND_BCAST = 16'h0080;
  localparam int unsigned REC_WORDS  = 4;

  typedef enum logic [1:0] {
    LD_IDLE  = 2'd0,
    LD_FETCH = 2'd1,
    LD_FINAL = 2'd2
  } ld_state_e;
endpackage

// File: rtl/dmf_table.sv
module dmf_table #(
  parameter int ENTRIES = 16,
  parameter int WORD_W  = 16,
  parameter int IDX_W   = 4,
  parameter int KEY_W   = 3 * WORD_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [KEY_W-1:0]   wr_data,
  input  logic [KEY_W-1:0]   key,
  output logic [ENTRIES-1:0] hit,
  input  logic [IDX_W-1:0]   rd_idx,
  output logic [KEY_W-1:0]   rd_entry
);
  logic [ENTRIES-1:0][KEY_W-1:0] flat;

  // One register slot per entry so that every entry is compared in parallel.
  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    logic [KEY_W-1:0] ent_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        ent_q <= '0;
      end else if (wr_en && (wr_idx == IDX_W'(e))) begin
        ent_q <= wr_data;
      end
    end
    assign hit[e]  = (ent_q == key);
    assign flat[e] = ent_q;
  end

  assign rd_entry = flat[rd_idx];
endmodule

// File: rtl/dmf_loader.sv
module dmf_loader
  import dmf_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int WORD_W  = 16,
  parameter int MADDR_W = 16,
  parameter int CNT_W   = 5,
  parameter int IDX_W   = 4,
  parameter int KEY_W   = 3 * WORD_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [CNT_W-1:0]   count,
  input  logic [MADDR_W-1:0] ptr_in,
  input  logic               wide_mode,
  output logic               busy,
  output logic               done,
  output logic               mem_req,
  output logic [MADDR_W-1:0] mem_addr,
  input  logic               mem_ack,
  input  logic [WORD_W-1:0]  mem_rdata,
  output logic               wr_en,
  output logic [IDX_W-1:0]   wr_idx,
  output logic [KEY_W-1:0]   wr_data,
  output logic [ENTRIES-1:0] enable
);
  localparam int NARROW_REC = 2 * REC_WORDS;
  localparam int WIDE_REC   = 4 * REC_WORDS;

  ld_state_e          st_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [MADDR_W-1:0] ptr_q;
  logic [1:0]         widx_q;
  logic               wide_q;
  logic [IDX_W-1:0]   idx_q;
  logic [WORD_W-1:0]  w0_q, w1_q;
  logic [MADDR_W-1:0] off, rec;

  always_comb begin
    off = wide_q ? MADDR_W'({widx_q, 2'b00}) : MADDR_W'({widx_q, 1'b0});
    rec = wide_q ? MADDR_W'(WIDE_REC) : MADDR_W'(NARROW_REC);
  end

  assign mem_req  = (st_q != LD_IDLE);
  assign busy     = mem_req;
  assign mem_addr = ptr_q + off;
  assign wr_en    = (st_q == LD_FETCH) && mem_ack && (widx_q == 2'd3);
  assign wr_idx   = idx_q;
  assign wr_data  = {mem_rdata, w1_q, w0_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= LD_IDLE;
      cnt_q  <= '0;
      ptr_q  <= '0;
      widx_q <= '0;
      wide_q <= 1'b0;
      idx_q  <= '0;
      w0_q   <= '0;
      w1_q   <= '0;
      enable <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st_q)
        LD_IDLE: begin
          if (start) begin
            cnt_q  <= count;
            ptr_q  <= ptr_in;
            wide_q <= wide_mode;
            widx_q <= '0;
            st_q   <= (count != '0) ? LD_FETCH : LD_FINAL;
          end
        end
        LD_FETCH: begin
          if (mem_ack) begin
            case (widx_q)
              2'd0:    idx_q <= mem_rdata[IDX_W-1:0];
              2'd1:    w0_q  <= mem_rdata;
              2'd2:    w1_q  <= mem_rdata;
              default: ;
            endcase
            if (widx_q == 2'd3) begin
              widx_q <= '0;
              cnt_q  <= cnt_q - 1'b1;
              ptr_q  <= ptr_q + rec;
              if (cnt_q == CNT_W'(1)) st_q <= LD_FINAL;
            end else begin
              widx_q <= widx_q + 1'b1;
            end
          end
        end
        LD_FINAL: begin
          if (mem_ack) begin
            enable <= mem_rdata[ENTRIES-1:0];
            done   <= 1'b1;
            st_q   <= LD_IDLE;
          end
        end
        default: st_q <= LD_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dmf_decide.sv
module dmf_decide
  import dmf_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int WORD_W  = 16,
  parameter int KEY_W   = 3 * WORD_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               promisc_en,
  input  logic               allmc_en,
  input  logic               bcast_en,
  input  logic               dst_valid,
  input  logic [KEY_W-1:0]   dst_addr,
  input  logic [ENTRIES-1:0] hit_vec,
  input  logic [ENTRIES-1:0] enable,
  output logic               verdict_valid,
  output logic               verdict_accept,
  output logic [WORD_W-1:0]  verdict_kind
);
  logic s1_v, s1_uni, s1_grp, s1_bc, s1_hit;

  // Stage 1: rule flags and the masked table hit.
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v   <= 1'b0;
      s1_uni <= 1'b0;
      s1_grp <= 1'b0;
      s1_bc  <= 1'b0;
      s1_hit <= 1'b0;
    end else begin
      s1_v   <= dst_valid;
      s1_uni <= promisc_en && !dst_addr[0];
      s1_grp <= allmc_en && dst_addr[0];
      s1_bc  <= bcast_en && (&dst_addr);
      s1_hit <= |(hit_vec & enable);
    end
  end

  // Stage 2: fixed-priority verdict.
  always_ff @(posedge clk) begin
    if (rst) begin
      verdict_valid  <= 1'b0;
      verdict_accept <= 1'b0;
      verdict_kind   <= '0;
    end else begin
      verdict_valid  <= s1_v;
      verdict_accept <= 1'b0;
      verdict_kind   <= '0;
      if (s1_v) begin
        if (s1_uni) begin
          verdict_accept <= 1'b1;
          verdict_kind   <= WORD_W'(KIND_NONE);
        end else if (s1_grp) begin
          verdict_accept <= 1'b1;
          verdict_kind   <= WORD_W'(KIND_GROUP);
        end else if (s1_bc) begin
          verdict_accept <= 1'b1;
          verdict_kind   <= WORD_W'(KIND_BCAST);
        end else begin
          verdict_accept <= s1_hit;
        end
      end
    end
  end
endmodule

// File: rtl/dst_match_filter.sv
module dst_match_filter #(
  parameter int ENTRIES = 16,
  parameter int WORD_W  = 16,
  parameter int MADDR_W = 16,
  parameter int CNT_W   = 5
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       promisc_en,
  input  logic                       allmc_en,
  input  logic                       bcast_en,
  input  logic                       wide_mode,
  input  logic                       dst_valid,
  input  logic [3*WORD_W-1:0]        dst_addr,
  output logic                       verdict_valid,
  output logic                       verdict_accept,
  output logic [WORD_W-1:0]          verdict_kind,
  input  logic                       load_start,
  input  logic [CNT_W-1:0]           load_count,
  input  logic [MADDR_W-1:0]         load_ptr,
  output logic                       load_busy,
  output logic                       load_done,
  output logic                       mem_req,
  output logic [MADDR_W-1:0]         mem_addr,
  input  logic                       mem_ack,
  input  logic [WORD_W-1:0]          mem_rdata,
  output logic [ENTRIES-1:0]         cam_enable,
  input  logic                       host_reset_mode,
  input  logic [$clog2(ENTRIES)-1:0] host_entry,
  input  logic [1:0]                 host_port,
  output logic [WORD_W-1:0]          host_rdata
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int KEY_W = 3 * WORD_W;

  logic               tbl_wr;
  logic [IDX_W-1:0]   tbl_idx;
  logic [KEY_W-1:0]   tbl_data;
  logic [ENTRIES-1:0] hit_vec;
  logic [KEY_W-1:0]   rd_entry;

  dmf_table #(.ENTRIES(ENTRIES), .WORD_W(WORD_W), .IDX_W(IDX_W), .KEY_W(KEY_W)) u_tbl (
    .clk(clk), .rst(rst), .wr_en(tbl_wr), .wr_idx(tbl_idx), .wr_data(tbl_data),
    .key(dst_addr), .hit(hit_vec), .rd_idx(host_entry), .rd_entry(rd_entry)
  );

  dmf_loader #(.ENTRIES(ENTRIES), .WORD_W(WORD_W), .MADDR_W(MADDR_W), .CNT_W(CNT_W),
               .IDX_W(IDX_W), .KEY_W(KEY_W)) u_ld (
    .clk(clk), .rst(rst), .start(load_start), .count(load_count), .ptr_in(load_ptr),
    .wide_mode(wide_mode), .busy(load_busy), .done(load_done), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata), .wr_en(tbl_wr),
    .wr_idx(tbl_idx), .wr_data(tbl_data), .enable(cam_enable)
  );

  dmf_decide #(.ENTRIES(ENTRIES), .WORD_W(WORD_W), .KEY_W(KEY_W)) u_dec (
    .clk(clk), .rst(rst), .promisc_en(promisc_en), .allmc_en(allmc_en),
    .bcast_en(bcast_en), .dst_valid(dst_valid), .dst_addr(dst_addr),
    .hit_vec(hit_vec), .enable(cam_enable), .verdict_valid(verdict_valid),
    .verdict_accept(verdict_accept), .verdict_kind(verdict_kind)
  );

  // Host readback: port k yields word (2 - k), only in reset mode.
  always_ff @(posedge clk) begin
    if (rst || !host_reset_mode) begin
      host_rdata <= '0;
    end else begin
      case (host_port)
        2'd0:    host_rdata <= rd_entry[3*WORD_W-1:2*WORD_W];
        2'd1:    host_rdata <= rd_entry[2*WORD_W-1:WORD_W];
        2'd2:    host_rdata <= rd_entry[WORD_W-1:0];
        default: host_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/dmf_chk.sv
module dmf_chk #(
  parameter int WORD_W  = 16,
  parameter int MADDR_W = 16
) (
  input logic               clk,
  input logic               rst,
  input logic               dst_valid,
  input logic               verdict_valid,
  input logic               verdict_accept,
  input logic [WORD_W-1:0]  verdict_kind,
  input logic               mem_req,
  input logic               mem_ack,
  input logic [MADDR_W-1:0] mem_addr,
  input logic               load_busy,
  input logic               load_done,
  input logic               host_reset_mode,
  input logic [WORD_W-1:0]  host_rdata
);
  // R5
  verdict_lat_chk: assert property (@(posedge clk) disable iff (rst)
    dst_valid |-> ##2 verdict_valid);

  // R5
  verdict_src_chk: assert property (@(posedge clk) disable iff (rst)
    verdict_valid |-> $past(dst_valid, 2));

  // R2
  kind_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(verdict_kind));

  // R3
  kind_accept_chk: assert property (@(posedge clk) disable iff (rst)
    (verdict_kind != '0) |-> (verdict_valid && verdict_accept));

  // R6
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

  // R8
  done_drop_chk: assert property (@(posedge clk) disable iff (rst)
    load_done |-> (!load_busy && $past(load_busy)));

  // R8
  busy_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(load_busy) |-> load_done);

  // R11
  rdback_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(host_reset_mode) |-> (host_rdata == '0));
endmodule

bind dst_match_filter dmf_chk #(.WORD_W(WORD_W), .MADDR_W(MADDR_W)) u_chk (
  .clk(clk), .rst(rst), .dst_valid(dst_valid), .verdict_valid(verdict_valid),
  .verdict_accept(verdict_accept), .verdict_kind(verdict_kind), .mem_req(mem_req),
  .mem_ack(mem_ack), .mem_addr(mem_addr), .load_busy(load_busy), .load_done(load_done),
  .host_reset_mode(host_reset_mode), .host_rdata(host_rdata)
);

// File: tb/sim_dst_match_filter.sv
`timescale 1ns/1ps
module sim_dst_match_filter;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        promisc_en = 0, allmc_en = 0, bcast_en = 0, wide_mode = 0;
  logic        dst_valid = 0;
  logic [47:0] dst_addr = '0;
  logic        verdict_valid, verdict_accept;
  logic [15:0] verdict_kind;
  logic        load_start = 0;
  logic [4:0]  load_count = '0;
  logic [15:0] load_ptr = '0;
  logic        load_busy, load_done, mem_req;
  logic [15:0] mem_addr;
  logic        mem_ack = 0;
  logic [15:0] mem_rdata = '0;
  logic [15:0] cam_enable;
  logic        host_reset_mode = 0;
  logic [3:0]  host_entry = '0;
  logic [1:0]  host_port = '0;
  logic [15:0] host_rdata;

  always #4 clk = ~clk;

  dst_match_filter u0 (
    .clk(clk), .rst(rst), .promisc_en(promisc_en), .allmc_en(allmc_en),
    .bcast_en(bcast_en), .wide_mode(wide_mode), .dst_valid(dst_valid),
    .dst_addr(dst_addr), .verdict_valid(verdict_valid), .verdict_accept(verdict_accept),
    .verdict_kind(verdict_kind), .load_start(load_start), .load_count(load_count),
    .load_ptr(load_ptr), .load_busy(load_busy), .load_done(load_done),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .cam_enable(cam_enable), .host_reset_mode(host_reset_mode),
    .host_entry(host_entry), .host_port(host_port), .host_rdata(host_rdata)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit chk_on = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Memory image and expected read sequence.
  logic [15:0] mem [int];
  int q_addr[$];
  int q_kind[$];
  function automatic logic [15:0] rd_mem(input int a);
    return mem.exists(a) ? mem[a] : 16'h0000;
  endfunction

  // Behavioural reference model.
  logic [47:0] m_tbl [16];
  logic [15:0] m_en;
  logic        m_v1, m_v2, m_acc1, m_acc2, m_busy, m_done;
  logic [15:0] m_kind1, m_kind2, m_rd;
  string       m_tag1, m_tag2;
  logic [3:0]  m_idx;
  logic [15:0] m_w0, m_w1;
  int          pend_kind;
  logic [15:0] pend_data;
  int          wait_cnt = 0, lat_seed = 0;

  always @(posedge clk) begin
    if (rst) begin
      for (int e = 0; e < 16; e++) m_tbl[e] <= '0;
      m_en <= '0; m_v1 <= 0; m_v2 <= 0; m_acc1 <= 0; m_acc2 <= 0;
      m_kind1 <= '0; m_kind2 <= '0; m_rd <= '0; m_busy <= 0; m_done <= 0;
      m_tag1 <= "R5"; m_tag2 <= "R5";
      q_addr.delete(); q_kind.delete();
    end else begin
      logic        acc;
      logic [15:0] kd;
      string       tg;
      m_v2 <= m_v1; m_acc2 <= m_acc1; m_kind2 <= m_kind1; m_tag2 <= m_tag1;
      m_v1 <= dst_valid;
      acc = 0; kd = 16'h0; tg = "R4";
      if (promisc_en && !dst_addr[0]) begin acc = 1; tg = "R1"; end
      else if (allmc_en && dst_addr[0]) begin acc = 1; kd = 16'h0100; tg = "R2"; end
      else if (bcast_en && dst_addr == {48{1'b1}}) begin acc = 1; kd = 16'h0080; tg = "R3"; end
      else for (int e = 0; e < 16; e++) if (m_en[e] && m_tbl[e] == dst_addr) acc = 1;
      m_acc1 <= dst_valid & acc; m_kind1 <= dst_valid ? kd : 16'h0; m_tag1 <= tg;
      if (!host_reset_mode || host_port == 2'd3) m_rd <= 16'h0;
      else m_rd <= m_tbl[host_entry][16*(2-host_port) +: 16];
      m_done <= 0;
      if (mem_ack) begin
        case (pend_kind)
          0: m_idx = pend_data[3:0];
          1: m_w0 = pend_data;
          2: m_w1 = pend_data;
          3: m_tbl[m_idx] <= {pend_data, m_w1, m_w0};
          default: begin m_en <= pend_data; m_busy <= 0; m_done <= 1; end
        endcase
      end
      if (load_start && !m_busy) begin
        int st, rc, b;
        st = wide_mode ? 4 : 2; rc = 4 * st; b = load_ptr;
        for (int r = 0; r < load_count; r++)
          for (int w = 0; w < 4; w++) begin
            q_addr.push_back((b + r * rc + w * st) & 16'hFFFF); q_kind.push_back(w);
          end
        q_addr.push_back((b + load_count * rc) & 16'hFFFF); q_kind.push_back(4);
        m_busy <= 1;
      end
    end
  end

  // Per-cycle comparison, then the memory responder.
  always @(negedge clk) begin
    cyc++;
    if (chk_on) begin
      chk("R5 verdict_valid", verdict_valid, m_v2);
      chk({m_tag2, " verdict_accept"}, verdict_accept, m_acc2);
      chk({m_tag2, " verdict_kind"}, verdict_kind, m_kind2);
      chk("R10 load_busy", load_busy, m_busy);
      chk("R8 load_done", load_done, m_done);
      chk("R8 cam_enable", cam_enable, m_en);
      chk("R11 host_rdata", host_rdata, m_rd);
      chk("R6 mem_req", mem_req, m_busy);
    end
    if (mem_ack) begin
      mem_ack = 0;
    end else if (mem_req && !rst) begin
      if (wait_cnt > 0) wait_cnt--;
      else if (q_addr.size() == 0) begin
        chk("R10 unexpected read", mem_addr, 16'hFFFF);
      end else begin
        int a;
        a = q_addr.pop_front();
        pend_kind = q_kind.pop_front();
        chk(pend_kind == 4 ? "R8 enable addr" : "R7 record addr", mem_addr, a[15:0]);
        pend_data = rd_mem(a);
        mem_rdata = pend_data;
        mem_ack = 1;
        lat_seed++;
        wait_cnt = lat_seed % 3;
      end
    end
  end

  // Watchdog
  always @(negedge clk) begin
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected below 150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic put_rec(input int base, input int r, input bit wide, input logic [15:0] slot,
                         input logic [47:0] a);
    int st;
    st = wide ? 4 : 2;
    mem[base + r * 4 * st]          = slot;
    mem[base + r * 4 * st + st]     = a[15:0];
    mem[base + r * 4 * st + 2 * st] = a[31:16];
    mem[base + r * 4 * st + 3 * st] = a[47:32];
  endtask

  task automatic run_load(input logic [4:0] n, input logic [15:0] p, input bit wide);
    @(negedge clk);
    load_start = 1; load_count = n; load_ptr = p; wide_mode = wide;
    @(negedge clk);
    load_start = 0;
    while (load_busy) @(negedge clk);
  endtask

  task automatic expect_verdict(input string tag, input logic [47:0] a,
                                input logic acc, input logic [15:0] kd);
    @(negedge clk);
    dst_valid = 1; dst_addr = a;
    @(negedge clk);
    dst_valid = 0;
    @(negedge clk);
    chk({tag, " valid"}, verdict_valid, 1'b1);
    chk({tag, " accept"}, verdict_accept, acc);
    chk({tag, " kind"}, verdict_kind, kd);
  endtask

  task automatic expect_read(input string tag, input bit md, input logic [3:0] e,
                             input logic [1:0] p, input logic [15:0] exp);
    @(negedge clk);
    host_reset_mode = md; host_entry = e; host_port = p;
    @(negedge clk);
    chk(tag, host_rdata, exp);
  endtask

  localparam logic [47:0] A2  = {16'h5544, 16'h3322, 16'h1100};
  localparam logic [47:0] A5  = {16'hE0D0, 16'hC0B0, 16'hA002};
  localparam logic [47:0] A7  = {16'h7772, 16'h7771, 16'h7770};
  localparam logic [47:0] A15 = {16'h0F03, 16'h0F02, 16'h0F01};
  localparam logic [47:0] B2  = {16'h0202, 16'h0201, 16'h0200};
  localparam logic [47:0] B9  = {16'h0909, 16'h0908, 16'h0906};
  localparam logic [47:0] UNI = 48'h1234_5678_9ABC;
  localparam logic [47:0] GRP = 48'h1234_5678_9ABD;
  localparam logic [47:0] ONES = {48{1'b1}};

  initial begin
    put_rec(16'h0100, 0, 0, 16'hABC2, A2);
    put_rec(16'h0100, 1, 0, 16'h0015, A5);
    put_rec(16'h0100, 2, 0, 16'h0007, A7);
    put_rec(16'h0100, 3, 0, 16'hFFFF, A15);
    mem[16'h0120] = 16'h8024;
    put_rec(16'h0400, 0, 1, 16'h0002, B2);
    put_rec(16'h0400, 1, 1, 16'h0009, B9);
    mem[16'h0420] = 16'h0204;
    mem[16'h0500] = 16'hFFFF;

    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk_on = 1;
    // R12 reset state
    chk("R12 verdict_valid", verdict_valid, 1'b0);
    chk("R12 load_busy", load_busy, 1'b0);
    chk("R12 cam_enable", cam_enable, 16'h0);
    chk("R12 mem_req", mem_req, 1'b0);
    expect_read("R12 slot readback", 1, 4'd2, 2'd2, 16'h0000);

    // R6 R7 R8 narrow load of four records
    run_load(5'd4, 16'h0100, 0);
    chk("R8 enable after narrow load", cam_enable, 16'h8024);
    chk("R6 read list drained", q_addr.size(), 0);
    expect_verdict("R4 slot 2", A2, 1, 16'h0000);
    expect_verdict("R4 slot 5", A5, 1, 16'h0000);
    expect_verdict("R4 slot 7 disabled", A7, 0, 16'h0000);
    expect_verdict("R4 slot 15 group addr", A15, 1, 16'h0000);
    expect_verdict("R4 no match", UNI, 0, 16'h0000);

    promisc_en = 1;
    expect_verdict("R1 promisc unicast", UNI, 1, 16'h0000);
    expect_verdict("R1 promisc ignores group", GRP, 0, 16'h0000);
    allmc_en = 1;
    expect_verdict("R2 group", GRP, 1, 16'h0100);
    bcast_en = 1;
    expect_verdict("R2 group before broadcast", ONES, 1, 16'h0100);
    expect_verdict("R1 promisc before table", A2, 1, 16'h0000);
    allmc_en = 0; promisc_en = 0;
    expect_verdict("R3 broadcast", ONES, 1, 16'h0080);
    expect_verdict("R3 near broadcast", 48'hFFFF_FFFF_FFFE, 0, 16'h0000);
    expect_verdict("R4 table with broadcast on", A15, 1, 16'h0000);

    // R5 back-to-back strobes, compared per cycle by the model
    @(negedge clk);
    for (int i = 0; i < 6; i++) begin
      dst_valid = 1;
      dst_addr = (i % 3 == 0) ? A2 : (i % 3 == 1) ? ONES : UNI;
      bcast_en = i[0];
      @(negedge clk);
    end
    dst_valid = 0; bcast_en = 0;
    repeat (3) @(negedge clk);

    // R7 wide load; R10 a second start mid-load is ignored
    @(negedge clk);
    load_start = 1; load_count = 5'd2; load_ptr = 16'h0400; wide_mode = 1;
    @(negedge clk);
    load_start = 0;
    repeat (3) @(negedge clk);
    load_start = 1; load_count = 5'd3; load_ptr = 16'h0800; wide_mode = 0;
    @(negedge clk);
    load_start = 0;
    while (load_busy) @(negedge clk);
    chk("R10 enable after wide load", cam_enable, 16'h0204);
    expect_verdict("R6 overwritten slot old addr", A2, 0, 16'h0000);
    expect_verdict("R6 overwritten slot new addr", B2, 1, 16'h0000);
    expect_verdict("R7 wide slot 9", B9, 1, 16'h0000);
    expect_verdict("R4 slot 5 now disabled", A5, 0, 16'h0000);

    // R9 zero-count load: only the enable word
    run_load(5'd0, 16'h0500, 0);
    chk("R9 enable only", cam_enable, 16'hFFFF);
    expect_verdict("R9 slot 7 enabled", A7, 1, 16'h0000);

    // R11 readback
    expect_read("R11 port 0", 1, 4'd9, 2'd0, 16'h0909);
    expect_read("R11 port 1", 1, 4'd9, 2'd1, 16'h0908);
    expect_read("R11 port 2", 1, 4'd9, 2'd2, 16'h0906);
    expect_read("R11 port 3", 1, 4'd9, 2'd3, 16'h0000);
    expect_read("R11 outside reset mode", 0, 4'd9, 2'd0, 16'h0000);
    expect_read("R11 slot 15", 1, 4'd15, 2'd2, 16'h0F01);

    repeat (4) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule